// File: doc/BRIEF.md
# Fractional-N Modulus Sequencer

This block steers the feedback divider of a frequency synthesizer so that its average division ratio is a fraction. Once in every reference period it adds a small fraction word into a modulo-16 accumulator. When that addition wraps, the divider uses N+1 for the period that follows. Otherwise it uses N. Over sixteen periods the ratio is N+1 in exactly F of them, so the average ratio is N + F/16.

The integer part N is built from two fields of a dual-modulus divider, B and A, as B·P + A, where P is a fixed prescaler factor. One 19-bit configuration word carries the fraction field together with the A and B fields.

The accumulator value after each step is also brought out as a residue, which a later phase-correction stage can use to cancel the sawtooth error. A new configuration word is held pending until the next reference-period step, so a period never starts with a mix of old and new fields.

Top module: `fracn_divctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `residue` is 0, `modSel` is 0 and `ratio` is 0, and the pending configuration word is 0.
- R2: Each cycle with `refTick` high adds the pending fraction field F (word bits [3:0]) to the 4-bit accumulator modulo 16. The result appears on `residue` one cycle later.
- R3: `modSel` is 1 for the period after a step exactly when that step's addition carried out of 4 bits. Otherwise it is 0.
- R4: After a step, `ratio` equals B·P + A + `modSel`. A is word bits [8:4], B is word bits [18:9], and the values are taken from the word pending at the step.
- R5: Without a `refTick`, `residue`, `modSel` and `ratio` keep their values, even when a word is written.
- R6: A word written with `wrEn` is used from the next `refTick` on. A write in the same cycle as a `refTick` is not used by that step; it is used by the one after.
- R7: With F held constant, any 16 consecutive steps give `modSel` = 1 in exactly F of them.
- R8: With F = 0, `modSel` never goes high. With F = 15, it is high in 15 of every 16 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle strobe marking the start of a reference period |
| wrEn | input | 1 | Write strobe for the configuration word |
| wrWord | input | 19 | Configuration word: {B[9:0], A[4:0], F[3:0]} |
| modSel | output | 1 | 1 when the current period divides by N+1 |
| ratio | output | 16 | Integer division ratio for the current period |
| residue | output | 4 | Accumulator contents after the latest step |

## Verification
On every cycle, assertions check four things:
- a step advances the residue by the fraction modulo 16;
- the N+1 select is high exactly when the residue wrapped;
- outputs hold still between steps;
- a zero fraction never selects N+1.

Other behaviours only the bench scenarios can show:
- the exact ratio arithmetic from the A and B fields;
- the deferred use of a write that coincides with a step;
- the count of N+1 periods over 16-step windows for several fractions.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic advance;   // step the accumulator and reload the ratio
    logic capture;   // a new word is being taken into the pending register
  } fracnStrobe_t;
endpackage

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrWord,
  output fracnStrobe_t      strobe,
  output logic [WORD_W-1:0] cfgWord
);
  logic [WORD_W-1:0] pendingWord;

  always_comb begin
    strobe.advance = refTick;
    strobe.capture = wrEn;
  end

  // The step in this cycle sees the old word; the write lands after it
  always_ff @(posedge clk) begin
    if (!rstN)       pendingWord <= '0;
    else if (wrEn)   pendingWord <= wrWord;
  end

  assign cfgWord = pendingWord;

  a_r6_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cfgWord));
endmodule

// File: rtl/fracn_dp.sv
module fracn_dp
  import fracn_pkg::*;
#(
  parameter int FRAC_W   = 4,
  parameter int A_W      = 5,
  parameter int B_W      = 10,
  parameter int PRESCALE = 32,
  parameter int RATIO_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fracnStrobe_t              strobe,
  input  logic [FRAC_W+A_W+B_W-1:0] cfgWord,
  output logic [FRAC_W-1:0]         residue,
  output logic                      modSel,
  output logic [RATIO_W-1:0]        ratio
);
  logic [FRAC_W-1:0]  fracF;
  logic [A_W-1:0]     fieldA;
  logic [B_W-1:0]     fieldB;
  logic [FRAC_W:0]    nextSum;
  logic [RATIO_W-1:0] baseRatio;

  assign fracF  = cfgWord[FRAC_W-1:0];
  assign fieldA = cfgWord[FRAC_W +: A_W];
  assign fieldB = cfgWord[FRAC_W+A_W +: B_W];

  always_comb begin
    nextSum   = {1'b0, residue} + {1'b0, fracF};
    baseRatio = RATIO_W'(fieldB) * RATIO_W'(PRESCALE) + RATIO_W'(fieldA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      residue <= '0;
      modSel  <= 1'b0;
      ratio   <= '0;
    end else if (strobe.advance) begin
      residue <= nextSum[FRAC_W-1:0];
      modSel  <= nextSum[FRAC_W];
      ratio   <= baseRatio + RATIO_W'(nextSum[FRAC_W]);
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (residue == '0 && !modSel && ratio == '0));

  a_r2_residue_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> residue == FRAC_W'($past(residue) + $past(fracF)));

  a_r3_wrap_select: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (modSel == (residue < $past(residue))));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(residue) && $stable(modSel) && $stable(ratio)));

  a_r8_zero_fraction: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && fracF == '0) |=> !modSel);
endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl
  import fracn_pkg::*;
#(
  parameter int FRAC_W   = 4,
  parameter int A_W      = 5,
  parameter int B_W      = 10,
  parameter int PRESCALE = 32
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   refTick,
  input  logic                                   wrEn,
  input  logic [FRAC_W+A_W+B_W-1:0]              wrWord,
  output logic                                   modSel,
  output logic [B_W+$clog2(PRESCALE)+1-1:0]      ratio,
  output logic [FRAC_W-1:0]                      residue
);
  localparam int WORD_W  = FRAC_W + A_W + B_W;
  localparam int RATIO_W = B_W + $clog2(PRESCALE) + 1;

  fracnStrobe_t      strobe;
  logic [WORD_W-1:0] cfgWord;

  fracn_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn),
    .wrWord(wrWord), .strobe(strobe), .cfgWord(cfgWord)
  );

  fracn_dp #(
    .FRAC_W(FRAC_W), .A_W(A_W), .B_W(B_W),
    .PRESCALE(PRESCALE), .RATIO_W(RATIO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWord(cfgWord),
    .residue(residue), .modSel(modSel), .ratio(ratio)
  );
endmodule

// File: tb/fracn_divctl_bench.sv
`timescale 1ns/1ps
module fracn_divctl_bench;
  localparam int P = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [18:0] wrWord = '0;
  logic        modSel;
  logic [15:0] ratio;
  logic [3:0]  residue;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  int mPend = 0, mAcc = 0, mMod = 0, mRatio = 0;
  int winCount;

  always #2 clk = ~clk;

  fracn_divctl u_fracn_divctl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn),
    .wrWord(wrWord), .modSel(modSel), .ratio(ratio), .residue(residue)
  );

  function automatic logic [18:0] mk(int b, int a, int f);
    return {10'(b), 5'(a), 4'(f)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    check(residue == 4'(mAcc), {req, " residue"}, residue, mAcc);
    check(modSel == 1'(mMod), {req, " modSel"}, modSel, mMod);
    check(ratio == 16'(mRatio), {req, " ratio"}, ratio, mRatio);
  endtask

  task automatic step(bit tk, bit wr, logic [18:0] w, string req);
    int s;
    @(negedge clk);
    refTick = tk; wrEn = wr; wrWord = w;
    @(posedge clk);
    if (tk) begin
      s = mAcc + (mPend & 15);
      mMod = (s > 15) ? 1 : 0;
      mAcc = s & 15;
      mRatio = ((mPend >> 9) & 1023) * P + ((mPend >> 4) & 31) + mMod;
    end
    if (wr) mPend = int'(w);
    #1;
    compareAll(req);
  endtask

  task automatic window(int f, string req);
    winCount = 0;
    for (int i = 0; i < 16; i++) begin
      step(1, 0, '0, req);
      if (modSel) winCount++;
    end
    check(winCount == f, req, winCount, f);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    compareAll("R1 in reset");
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    compareAll("R1 after reset");
    step(1, 0, '0, "R1 step with zero word");

    // R2 R3 R4: F=5 A=3 B=10
    step(0, 1, mk(10, 3, 5), "R6 write no tick");
    for (int i = 0; i < 8; i++) begin
      step(1, 0, '0, "R2 R3 R4 F5");
      step(0, 0, '0, "R5 idle");
    end
    window(5, "R7 F5 window");

    // R5: writes without ticks leave outputs alone
    step(0, 1, mk(700, 31, 9), "R5 write holds outputs");
    step(0, 0, '0, "R5 idle after write");
    step(1, 0, '0, "R4 new fields A31 B700");
    window(9, "R7 F9 window");

    // R6: write coincident with tick is used one tick later
    step(1, 1, mk(4, 2, 1), "R6 coincident write");
    step(1, 0, '0, "R6 deferred use");
    window(1, "R7 F1 window");

    // R8: extremes
    step(0, 1, mk(1023, 31, 0), "R8 write F0");
    window(0, "R8 F0 window");
    step(0, 1, mk(1023, 31, 15), "R8 write F15");
    window(15, "R8 F15 window");

    // R1: reset mid-run clears everything
    @(negedge clk); rstN = 1'b0; refTick = 1'b0; wrEn = 1'b0;
    @(posedge clk); #1;
    mAcc = 0; mMod = 0; mRatio = 0; mPend = 0;
    compareAll("R1 mid-run reset");
    @(negedge clk); rstN = 1'b1;
    step(1, 0, '0, "R1 pending cleared");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule